// File: doc/BRIEF.md
# Multiphase Clock-Enable Phase Generator

This block derives a set of slow square waves, evenly staggered in phase, from one fast clock. It uses no PLL or DLL outputs. A one-hot ring register circulates a single token. Each position of the ring is an enable slot. Every output is a flop on the fast clock: it is set when the token reaches the output's rising slot, and cleared half a period later. Because each output leaves the block straight from a flop on the same clock, the phase relationships are fixed and routing adds little skew.

The ring width equals the ratio between the fast clock and the output clock. The ratio is either 8 or 16 and is set by a parameter. With eight outputs, neighbouring outputs are 45 degrees apart in either ratio.

A run control stops all outputs at once. A restart begins cleanly from the seed position and needs no lock or training step. A reseed control forces the ring back to its seed position while running.

Top module: `multiphase_clkgen`

## Requirements
- R1: The slot ring is RATIO bits wide and always holds exactly one set bit. After reset it sits at slot 0 (bit 0). It advances one slot toward the higher bit index, wrapping from slot RATIO-1 to slot 0, on each clock edge on which it runs.
- R2: Output bit k rises after the clock edge on which slot k*RATIO/NUM_PHASE is active. Phase 0 (bit 0) therefore goes high on the first running edge after reset is released. With NUM_PHASE=8, consecutive bits are 45 degrees apart for both RATIO=8 and RATIO=16.
- R3: Once started, every output is a square wave with a period of RATIO fast cycles. It is high for RATIO/2 cycles and low for RATIO/2 cycles.
- R4: After any seed load (reset, restart or reseed), output k stays low until its own rising slot is first reached.
- R5: While run_en is low, all outputs are low after the next clock edge, and the ring holds its position.
- R6: The first edge with run_en high after a stop loads the seed and keeps all outputs low. The edges after that follow the same sequence as after reset.
- R7: While rst is high, all outputs are low after the clock edge, and the ring returns to slot 0.
- R8: reseed high on an edge with run_en high loads the seed and drives all outputs low. A stop (run_en low) takes priority over reseed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, RATIO times the output rate |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High to run, low to stop all outputs |
| reseed | input | 1 | High to return the ring to slot 0 |
| phase_out | output | NUM_PHASE | Phase-staggered outputs; bit k lags bit 0 by k*360/NUM_PHASE degrees |

## Verification
A ring that loses its token, or holds two tokens, shows at the ports within one output period: some output stops toggling, or two outputs rise on the same edge. A wrong slot decode shows as an edge in the wrong cycle on the first output that uses that slot. A stop or restart that is handled wrongly shows on the very next edge, because outputs would then be high when they should be low, or their phase would be shifted from the sequence counted from the seed. Every output is compared on every cycle against a cycle count kept from the last seed load, for both ratios at once.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;
  // Slot on which output k goes high: outputs are spread evenly around the ring.
  function automatic int rise_slot(input int k, input int ratio, input int nphase);
    return k * (ratio / nphase);
  endfunction

  // Slot on which output k goes low: half a ring later.
  function automatic int fall_slot(input int k, input int ratio, input int nphase);
    return (k * (ratio / nphase) + ratio / 2) % ratio;
  endfunction
endpackage

// File: rtl/phase_run_ctrl.sv
module phase_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic reseed,
  output logic advance,
  output logic load_seed,
  output logic force_low
);
  logic was_running_q;

  always_ff @(posedge clk) begin
    if (rst) was_running_q <= 1'b1;
    else     was_running_q <= run_en;
  end

  // Priority: stop, then seed load (restart or reseed), then normal advance.
  always_comb begin
    force_low = !run_en;
    load_seed = run_en && (!was_running_q || reseed);
    advance   = run_en && was_running_q && !reseed;
  end

  // R6: after a stopped cycle, a running edge must load the seed, never advance
  a_r6_restart_loads: assert property (@(posedge clk) disable iff (rst)
    (!run_en ##1 run_en) |-> (load_seed && !advance));
endmodule

// File: rtl/phase_slot_ring.sv
module phase_slot_ring #(
  parameter int RATIO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             load_seed,
  output logic [RATIO-1:0] slot_vec
);
  localparam logic [RATIO-1:0] SEED = {{(RATIO-1){1'b0}}, 1'b1};

  logic [RATIO-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst || load_seed) ring_q <= SEED;
    else if (advance)     ring_q <= {ring_q[RATIO-2:0], ring_q[RATIO-1]};
  end

  assign slot_vec = ring_q;

  // R1: exactly one token in the ring
  a_r1_one_token: assert property (@(posedge clk) disable iff (rst)
    ($countones(ring_q) == 1));

  // R5: ring holds its position when neither advancing nor loading
  a_r5_ring_holds: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load_seed) |=> (ring_q == $past(ring_q)));
endmodule

// File: rtl/phase_out_slice.sv
module phase_out_slice #(
  parameter int RATIO = 16,
  parameter int RISE  = 0,
  parameter int FALL  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             clear,
  input  logic [RATIO-1:0] slot_vec,
  output logic             phase_q
);
  localparam int HALF  = RATIO / 2;
  localparam int CNT_W = $clog2(RATIO) + 1;

  // Final output flop on the fast clock: set on the rising slot, cleared on the falling slot.
  always_ff @(posedge clk) begin
    if (rst || clear)      phase_q <= 1'b0;
    else if (advance) begin
      if (slot_vec[RISE])      phase_q <= 1'b1;
      else if (slot_vec[FALL]) phase_q <= 1'b0;
    end
  end

  // Checker counter: length of the current high stretch
  logic [CNT_W-1:0] high_len;
  always_ff @(posedge clk) begin
    if (rst || !phase_q) high_len <= '0;
    else                 high_len <= high_len + 1'b1;
  end

  // R3: no high stretch exceeds half a period
  a_r3_high_bounded: assert property (@(posedge clk) disable iff (rst)
    (high_len <= CNT_W'(HALF)));
endmodule

// File: rtl/multiphase_clkgen.sv
module multiphase_clkgen #(
  parameter int RATIO     = 16,
  parameter int NUM_PHASE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 reseed,
  output logic [NUM_PHASE-1:0] phase_out
);
  import phase_gen_pkg::*;

  logic             advance;
  logic             load_seed;
  logic             force_low;
  logic [RATIO-1:0] slot_vec;

  phase_run_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .reseed    (reseed),
    .advance   (advance),
    .load_seed (load_seed),
    .force_low (force_low)
  );

  phase_slot_ring #(.RATIO(RATIO)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .load_seed (load_seed),
    .slot_vec  (slot_vec)
  );

  for (genvar k = 0; k < NUM_PHASE; k++) begin : g_phase
    phase_out_slice #(
      .RATIO (RATIO),
      .RISE  (rise_slot(k, RATIO, NUM_PHASE)),
      .FALL  (fall_slot(k, RATIO, NUM_PHASE))
    ) u_slice (
      .clk      (clk),
      .rst      (rst),
      .advance  (advance),
      .clear    (force_low || load_seed),
      .slot_vec (slot_vec),
      .phase_q  (phase_out[k])
    );
  end

  // R2: phase 0 is high after an advancing edge at slot 0
  a_r2_phase0_rises: assert property (@(posedge clk) disable iff (rst)
    (advance && slot_vec[0]) |=> phase_out[0]);

  // R5: stop forces every output low on the next edge
  a_r5_stop_low: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (phase_out == '0));

  // R8: a reseed while running clears outputs and returns the ring to slot 0
  a_r8_reseed_clears: assert property (@(posedge clk) disable iff (rst)
    (run_en && reseed) |=> ((phase_out == '0) && slot_vec[0]));
endmodule

// File: tb/sim_multiphase_clkgen.sv
module sim_multiphase_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b1;
  logic reseed = 1'b0;
  logic [7:0] out16, out8;

  int checks = 0;
  int fails  = 0;
  int n16    = -1;   // running edges since the last seed load, -1 = none yet
  int cycles = 0;
  logic run_q_m = 1'b1;

  always #5 clk = ~clk;

  multiphase_clkgen #(.RATIO(16), .NUM_PHASE(8)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .reseed(reseed), .phase_out(out16));
  multiphase_clkgen #(.RATIO(8), .NUM_PHASE(8)) u1 (
    .clk(clk), .rst(rst), .run_en(run_en), .reseed(reseed), .phase_out(out8));

  // Expected outputs from the requirements: bit k rises at slot k*ratio/8 (R2),
  // high for ratio/2 (R3), low before its first rise (R4).
  function automatic logic [7:0] expect_out(input int n, input int ratio);
    logic [7:0] e = '0;
    for (int k = 0; k < 8; k++) begin
      int r = k * (ratio / 8);
      if (n >= r && ((n - r) % ratio) < ratio / 2) e[k] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (n=%0d)", tag, act, exp, n16);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at the next negedge.
  task automatic step(input logic r, input logic run, input logic rs, input string tag);
    rst = r; run_en = run; reseed = rs;
    @(posedge clk);
    if (r)                      begin n16 = -1; run_q_m = 1'b1; end
    else if (!run)              begin n16 = -1; run_q_m = 1'b0; end
    else if (!run_q_m || rs)    begin n16 = -1; run_q_m = 1'b1; end
    else                        n16++;
    @(negedge clk);
    check(out16, (n16 < 0) ? 8'h00 : expect_out(n16, 16), {tag, " x16"});
    check(out8,  (n16 < 0) ? 8'h00 : expect_out(n16, 8),  {tag, " x8"});
  endtask

  task automatic t_reset;       // R7
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R7 reset low");
  endtask

  task automatic t_free_run;    // R1 R2 R3 R4
    step(1'b0, 1'b1, 1'b0, "R2 phase0 first edge");
    for (int i = 0; i < 48; i++) step(1'b0, 1'b1, 1'b0, "R3 R4 R1 pattern");
  endtask

  task automatic t_stop_restart; // R5 R6
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R5 stopped low");
    step(1'b0, 1'b1, 1'b0, "R6 restart load");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, "R6 after restart");
  endtask

  task automatic t_reseed;      // R8
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, "R8 pre-run");
    step(1'b0, 1'b1, 1'b1, "R8 reseed clears");
    for (int i = 0; i < 18; i++) step(1'b0, 1'b1, 1'b0, "R8 after reseed");
    step(1'b0, 1'b0, 1'b1, "R8 stop over reseed");
    step(1'b0, 1'b1, 1'b0, "R8 R6 restart");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, "R8 resumed");
  endtask

  task automatic t_short_stop;  // R5 R6: one-cycle stop mid-high
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R5 pre");
    step(1'b0, 1'b0, 1'b0, "R5 single stop");
    step(1'b0, 1'b1, 1'b0, "R6 reload");
    for (int i = 0; i < 34; i++) step(1'b0, 1'b1, 1'b0, "R6 realigned");
  endtask

  task automatic t_reset_midrun; // R7
    step(1'b1, 1'b1, 1'b0, "R7 reset mid-run");
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, 1'b0, "R7 R2 after reset");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run();
    t_stop_restart();
    t_reseed();
    t_short_stop();
    t_reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule